// File: doc/BRIEF.md
# Serial Flash Write-Enable Latch Controller

This block is the device-side command front end of a serial flash part. It takes in one-byte commands on a serial clock while an active-low select is held low, and it keeps the write enable latch that the program, erase and register-write paths check before they act. Each command byte can arrive on one line, two lines or four lines. A two-bit lane-mode input picks the width. The block registers that input only while select is high, so the width stays fixed for the whole command.

A command takes effect only when select goes high on the first clock edge after the last bit group. If select goes high early, the partial byte is dropped. If more clocks arrive while select is still low, the byte is also dropped. Three opcodes are decoded: 06h sets the latch, 04h clears it, and 50h clears the error flag and the latch together. An external pulse raises a sticky protection-error flag. While that flag is set, 04h cannot clear the latch. Any other opcode has no effect.

Top module: `wel_cmd_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the latch output `wel` and the error output `prot_err` are both 0.
- R2: Lane mode 00 (and the unused code 11) takes the byte on `dq[0]` over 8 rising edges, most significant bit first.
- R3: Lane mode 01 takes the byte on `dq[1:0]` over 4 rising edges, most significant pair first, with `dq[1]` as the more significant bit of each pair.
- R4: Lane mode 10 takes the byte on `dq[3:0]` over 2 rising edges, upper nibble first, with `dq[3]` as the most significant bit of each nibble. For example, nibbles 6h then 0h give 60h, not 06h.
- R5: A command runs only on the first rising edge with `sel_n` high after exactly a full byte of groups. If select is released after fewer groups, or one or more extra edges pass with select low, `wel` and `prot_err` do not change.
- R6: A completed 06h sets `wel` to 1, even when `prot_err` is set. A completed 04h clears `wel` when `prot_err` is 0.
- R7: A high `err_in` on a rising edge sets `prot_err`, which then stays set. While it is set, a completed 04h leaves `wel` unchanged.
- R8: A completed 50h clears both `prot_err` and `wel`.
- R9: A completed byte other than 06h, 04h or 50h leaves `wel` and `prot_err` unchanged.
- R10: `lane_mode` is registered only on edges where `sel_n` is high. Changing it while select is low does not affect the command in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; bits are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low command select |
| lane_mode | input | 2 | 00 single, 01 dual, 10 quad, 11 treated as single |
| dq | input | 4 | Command data lines |
| err_in | input | 1 | Pulse that raises the protection-error flag |
| wel | output | 1 | Write enable latch |
| prot_err | output | 1 | Sticky protection-error flag |

## Verification
The assertions assume that `sel_n` and `dq` change only away from the rising clock edge, and that `err_in` is a clean synchronous level. They also assume each select-low window starts from an idle counter, so a release edge compares a whole, uninterrupted byte. The bench drives every input on the falling edge and always holds select high for at least one edge between commands. It never raises `err_in` on the same edge as a release, so each expected flag value follows from a single cause.

// File: rtl/wel_pkg.sv
package wel_pkg;

  localparam int CMD_W  = 8;
  localparam int DQ_W   = 4;
  localparam int CNT_W  = $clog2(CMD_W + 1);

  typedef enum logic [1:0] {
    LM_X1  = 2'b00,
    LM_X2  = 2'b01,
    LM_X4  = 2'b10,
    LM_RSV = 2'b11
  } lane_mode_e;

  localparam logic [CMD_W-1:0] OP_SET_WEL  = 8'h06;
  localparam logic [CMD_W-1:0] OP_CLR_WEL  = 8'h04;
  localparam logic [CMD_W-1:0] OP_CLR_FLAG = 8'h50;

  // bits taken per clock edge for a lane mode
  function automatic logic [CNT_W-1:0] lanes_of(lane_mode_e m);
    case (m)
      LM_X2:   return CNT_W'(2);
      LM_X4:   return CNT_W'(4);
      default: return CNT_W'(1);
    endcase
  endfunction

  // shift one bit group into the assembly register, MSB first
  function automatic logic [CMD_W-1:0] shift_group(logic [CMD_W-1:0] sr,
                                                   logic [DQ_W-1:0]  d,
                                                   lane_mode_e       m);
    case (m)
      LM_X2:   return {sr[CMD_W-3:0], d[1:0]};
      LM_X4:   return {sr[CMD_W-5:0], d[3:0]};
      default: return {sr[CMD_W-2:0], d[0]};
    endcase
  endfunction

endpackage

// File: rtl/wel_cmd_shifter.sv
module wel_cmd_shifter
  import wel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic [1:0]       lane_mode,
  input  logic [DQ_W-1:0]  dq,
  output logic [CMD_W-1:0] code,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             overrun,
  output logic             byte_done
);

  lane_mode_e mode_q;
  logic [CMD_W-1:0] sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LM_X1;
      sr_q   <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
    end else if (sel_n) begin
      mode_q <= lane_mode_e'(lane_mode);
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
    end else if (cnt_q == CNT_W'(CMD_W)) begin
      ovr_q  <= 1'b1;
    end else begin
      sr_q   <= shift_group(sr_q, dq, mode_q);
      cnt_q  <= cnt_q + lanes_of(mode_q);
    end
  end

  assign code      = sr_q;
  assign bit_cnt   = cnt_q;
  assign overrun   = ovr_q;
  assign byte_done = (cnt_q == CNT_W'(CMD_W)) && !ovr_q;

endmodule

// File: rtl/wel_cmd_decode.sv
module wel_cmd_decode
  import wel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             byte_done,
  input  logic [CMD_W-1:0] code,
  output logic             release_evt,
  output logic             exec_set,
  output logic             exec_clr,
  output logic             exec_clrf
);

  logic sel_q;
  logic fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b1;
    else        sel_q <= sel_n;
  end

  assign release_evt = sel_n && !sel_q;
  assign fire        = release_evt && byte_done;
  assign exec_set    = fire && (code == OP_SET_WEL);
  assign exec_clr    = fire && (code == OP_CLR_WEL);
  assign exec_clrf   = fire && (code == OP_CLR_FLAG);

endmodule

// File: rtl/wel_state.sv
module wel_state (
  input  logic clk,
  input  logic rst_n,
  input  logic exec_set,
  input  logic exec_clr,
  input  logic exec_clrf,
  input  logic err_in,
  output logic wel,
  output logic prot_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prot_err <= 1'b0;
    else if (err_in)    prot_err <= 1'b1;
    else if (exec_clrf) prot_err <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     wel <= 1'b0;
    else if (exec_clrf)             wel <= 1'b0;
    else if (exec_set)              wel <= 1'b1;
    else if (exec_clr && !prot_err) wel <= 1'b0;
  end

endmodule

// File: rtl/wel_cmd_ctrl.sv
module wel_cmd_ctrl
  import wel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_n,
  input  logic [1:0]      lane_mode,
  input  logic [DQ_W-1:0] dq,
  input  logic            err_in,
  output logic            wel,
  output logic            prot_err
);

  logic [CMD_W-1:0] code;
  logic [CNT_W-1:0] bit_cnt;
  logic             overrun;
  logic             byte_done;
  logic             release_evt;
  logic             exec_set;
  logic             exec_clr;
  logic             exec_clrf;

  wel_cmd_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .lane_mode (lane_mode),
    .dq        (dq),
    .code      (code),
    .bit_cnt   (bit_cnt),
    .overrun   (overrun),
    .byte_done (byte_done)
  );

  wel_cmd_decode u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_n       (sel_n),
    .byte_done   (byte_done),
    .code        (code),
    .release_evt (release_evt),
    .exec_set    (exec_set),
    .exec_clr    (exec_clr),
    .exec_clrf   (exec_clrf)
  );

  wel_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_set  (exec_set),
    .exec_clr  (exec_clr),
    .exec_clrf (exec_clrf),
    .err_in    (err_in),
    .wel       (wel),
    .prot_err  (prot_err)
  );

endmodule

// File: rtl/wel_cmd_chk.sv
module wel_cmd_chk
  import wel_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sel_n,
  input logic             err_in,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             overrun,
  input logic             release_evt,
  input logic             exec_set,
  input logic             exec_clr,
  input logic             exec_clrf,
  input logic             wel,
  input logic             prot_err
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (!wel && !prot_err);
    end
  end

  // R5
  exec_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_set || exec_clr || exec_clrf) |-> (release_evt && !overrun));

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(CMD_W));

  // R9
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exec_set, exec_clr, exec_clrf}));

  // R6
  wel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(exec_set));

  // R8
  wel_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> ($past(exec_clrf) || ($past(exec_clr) && !$past(prot_err))));

  // R7
  blocked_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_clr && prot_err && wel) |=> wel);

  // R7
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_err) |-> $past(err_in));

  // R8
  err_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_err) |-> $past(exec_clrf));

  // R5
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !err_in) |=> ($stable(wel) && $stable(prot_err)));

endmodule

bind wel_cmd_ctrl wel_cmd_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_n       (sel_n),
  .err_in      (err_in),
  .bit_cnt     (bit_cnt),
  .overrun     (overrun),
  .release_evt (release_evt),
  .exec_set    (exec_set),
  .exec_clr    (exec_clr),
  .exec_clrf   (exec_clrf),
  .wel         (wel),
  .prot_err    (prot_err)
);

// File: tb/sim_wel_cmd_ctrl.sv
module sim_wel_cmd_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1;
  logic [1:0] lane_mode = 2'b00;
  logic [3:0] dq = 4'h0;
  logic       err_in = 1'b0;
  logic       wel;
  logic       prot_err;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  wel_cmd_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .lane_mode (lane_mode),
    .dq        (dq),
    .err_in    (err_in),
    .wel       (wel),
    .prot_err  (prot_err)
  );

  // fields: [14:7] opcode, [6:5] lane mode, [4:3] kind (0 full, 1 overrun, 2 short),
  //         [2] error pulse first, [1] expected wel, [0] expected prot_err
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {8'h06, 2'b00, 2'd0, 1'b0, 1'b1, 1'b0},
    {8'h04, 2'b01, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'h06, 2'b10, 2'd0, 1'b0, 1'b1, 1'b0},
    {8'h04, 2'b00, 2'd1, 1'b0, 1'b1, 1'b0},
    {8'h04, 2'b10, 2'd2, 1'b0, 1'b1, 1'b0},
    {8'h04, 2'b01, 2'd0, 1'b1, 1'b1, 1'b1},
    {8'h33, 2'b00, 2'd0, 1'b0, 1'b1, 1'b1},
    {8'h50, 2'b10, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'h06, 2'b01, 2'd1, 1'b0, 1'b0, 1'b0},
    {8'h60, 2'b10, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'h06, 2'b01, 2'd0, 1'b0, 1'b1, 1'b0},
    {8'h50, 2'b00, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'h06, 2'b11, 2'd0, 1'b0, 1'b1, 1'b0},
    {8'h04, 2'b00, 2'd0, 1'b0, 1'b0, 1'b0},
    {8'h06, 2'b00, 2'd0, 1'b1, 1'b1, 1'b1},
    {8'h50, 2'b01, 2'd0, 1'b0, 1'b0, 1'b0}
  };

  function automatic int width_of(logic [1:0] m);
    if (m == 2'b01) return 2;
    if (m == 2'b10) return 4;
    return 1;
  endfunction

  // group g of opcode op for a given line count, line 0 the least significant
  function automatic logic [3:0] group_of(logic [7:0] op, int w, int g);
    logic [3:0] r = 4'h0;
    for (int b = 0; b < w; b++) r[b] = op[7 - g*w - (w-1-b)];
    return r;
  endfunction

  function automatic string op_tag(logic [7:0] op, logic [1:0] kind, logic perr);
    if (kind != 2'd0)  return "R5";
    if (op == 8'h06)   return "R6";
    if (op == 8'h04)   return perr ? "R7" : "R6";
    if (op == 8'h50)   return "R8";
    return "R9";
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    if (m == 2'b01) return "R3";
    if (m == 2'b10) return "R4";
    return "R2";
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic send(logic [7:0] op, logic [1:0] m, logic [1:0] kind, logic perr);
    int w = width_of(m);
    int n = 8 / w;
    if (kind == 2'd1) n = n + 1;
    if (kind == 2'd2) n = n - 1;
    @(negedge clk);
    sel_n = 1'b1; lane_mode = m; err_in = perr;
    @(negedge clk);
    err_in = 1'b0;
    for (int g = 0; g < n; g++) begin
      sel_n = 1'b0;
      dq = (g < 8 / w) ? group_of(op, w, g) : 4'h0;
      @(negedge clk);
    end
    sel_n = 1'b1;
    dq = 4'h0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "wel in reset", wel, 1'b0);
    check("R1", "prot_err in reset", prot_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "wel after reset", wel, 1'b0);
    check("R1", "prot_err after reset", prot_err, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [14:0] v = VEC[i];
      send(v[14:7], v[6:5], v[4:3], v[2]);
      check({op_tag(v[14:7], v[4:3], v[2]), "/", mode_tag(v[6:5])},
            $sformatf("vec %0d wel", i), wel, v[1]);
      check({op_tag(v[14:7], v[4:3], v[2]), "/", mode_tag(v[6:5])},
            $sformatf("vec %0d prot_err", i), prot_err, v[0]);
    end

    // R10: lane mode changed mid-command has no effect; quad 06h still decodes
    send(8'h04, 2'b00, 2'd0, 1'b0);
    @(negedge clk);
    sel_n = 1'b1; lane_mode = 2'b10;
    @(negedge clk);
    sel_n = 1'b0; dq = 4'h0;
    @(negedge clk);
    lane_mode = 2'b00; dq = 4'h6;
    @(negedge clk);
    sel_n = 1'b1; dq = 4'h0;
    @(negedge clk);
    check("R10", "wel after mid-command mode change", wel, 1'b1);

    // R7: error flag persists across commands that do not clear it
    send(8'h04, 2'b00, 2'd0, 1'b1);
    send(8'h06, 2'b10, 2'd0, 1'b0);
    check("R7", "prot_err sticky", prot_err, 1'b1);
    send(8'h04, 2'b10, 2'd0, 1'b0);
    check("R7", "wel kept by blocked clear", wel, 1'b1);

    // R1: reset returns both outputs to 0
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "wel on reset", wel, 1'b0);
    check("R1", "prot_err on reset", prot_err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule